// File: doc/BRIEF.md
# Partitioned Unsigned 32x32 Multiplier with Carry-Select Merge

This block multiplies two unsigned 32-bit operands and returns the complete 64-bit product. Each operand is cut into a low and a high 16-bit half. Four 16x16 array multipliers work side by side, one for each pairing of halves. Each array is a grid of AND-gate partial products and rows of full adders.

The four sub-products are merged in two levels. First, the two sub-products that share the same half of `b` are joined into a 48-bit partial result. Second, the two partial results are joined with a 16-bit offset. At every point where a carry would otherwise have to ripple into an upper 16-bit field, that field is computed twice: once unchanged and once plus one. The incoming carry then picks one of the two copies through a multiplexer.

In the final overlap, the lower 16-bit segment is added with a two-level carry-lookahead adder and the next segment with a ripple adder. A parameter chooses how the topmost plus-one copy is built. It is either a chain of half adders, or a full adder on the lowest bit followed by a 15-bit half-adder chain. A second parameter places one register on the product. That register has a synchronous active-low reset.

Top module: `pmul_top`

## Requirements
- R1: For every pair of 32-bit unsigned operands, `prod` equals the full 64-bit unsigned product a*b, with no truncation.
- R2: With the output register enabled (the default), `prod` shows the product of the operands sampled at the previous rising edge of `clk`, for new operands on every cycle.
- R3: While `rst_n` is low at a rising edge of `clk`, `prod` becomes all zeros on that edge, whatever the operand values.
- R4: `prod[15:0]` equals the low 16 bits of a[15:0]*b[15:0].
- R5: The carry from each pair merge into its top 16-bit field is applied correctly, both when that carry is 0 and when it is 1. For the pair built on half h of `b` (h = b[15:0] or b[31:16]), the carry is 1 exactly when ((a[15:0]*h) >> 16) + ((a[31:16]*h) mod 2^16) is at least 2^16.
- R6: The carry into the topmost 16 bits of the final merge is applied correctly, both when it is 0 and when it is 1. Let X = a*b[15:0] and Y = a*b[31:16]. Let c1 be the carry out of X[31:16]+Y[15:0]. The carry into the top field is the carry out of X[47:32]+Y[31:16]+c1.
- R7: If either operand is zero, `prod` is zero. If `b` is 1, `prod` equals `a`, zero-extended.
- R8: All-ones operands give `prod` = 64'hFFFF_FFFE_0000_0001. Operands that each have a single bit set, at any positions, give a single set bit at the sum of the two positions.
- R9: The split top-incrementer variant (`TOP_SPLIT_INC` = 1) gives the same product as the plain half-adder variant for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | 32 | Multiplicand, unsigned |
| b | input | 32 | Multiplier, unsigned |
| prod | output | 64 | Unsigned product, registered when `OUT_REG` is 1 |

## Verification
The bench targets the three carry-select points. For each one, it counts how many vectors drive the select line to 0 and how many drive it to 1, using the arithmetic stated in R5 and R6. It requires both counts to be non-zero. A design that wires a multiplexer backwards, or leaves it stuck, returns a product that is wrong by exactly 2^48 or 2^32 on about half of the random vectors.

Extreme operands are covered next. All-ones operands expose a dropped carry at the top of an array row. Walking single-bit operands catch a sub-multiplier whose halves are swapped, or a merge shifted by the wrong offset. Both show up as a set bit in the wrong place.

A plain and a split-incrementer instance run side by side on every vector, so a faulty lowest-bit full adder shows as a mismatch tagged with the variant requirement. A reset taken mid-stream must clear a non-zero product.

// File: rtl/pmul_pkg.sv
// Package pmul_pkg
// Shared constants and bit-level helpers for the partitioned multiplier.
// Assumes callers widen vectors to 64 bits before passing them to la_carry.
package pmul_pkg;

    // Width of one generate/propagate group inside the lookahead adder.
    localparam int unsigned CLA_GROUP_W = 4;

    // Sum output of a one-bit full adder.
    function automatic logic fa_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

    // Carry output of a one-bit full adder.
    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (x & y) | (x & c) | (y & c);
    endfunction

    // Flattened lookahead: carry into position n from generate/propagate
    // terms at positions 0..n-1 and the incoming carry cin.
    function automatic logic la_carry(input logic [63:0] g, input logic [63:0] p,
                                      input logic cin, input int n);
        logic res;
        logic chain;
        res = 1'b0;
        for (int j = 0; j < 64; j++) begin
            if (j < n) begin
                chain = g[j];
                for (int k = j + 1; k < 64; k++) begin
                    if (k < n) chain = chain & p[k];
                end
                res = res | chain;
            end
        end
        chain = cin;
        for (int k = 0; k < 64; k++) begin
            if (k < n) chain = chain & p[k];
        end
        return res | chain;
    endfunction

endpackage

// File: rtl/pmul_array.sv
// Module pmul_array
// Unsigned W x W array multiplier. Row r ANDs operand a with bit r of b and
// adds that partial product to the running upper sum through a row of full
// adders. The lowest sum bit of each row drops out as one product bit.
// Purely combinational; assumes W >= 2.
module pmul_array #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] p_o
);
    import pmul_pkg::*;

    logic [W:0][W-1:0] acc;     // running upper sum entering each row
    logic [W-1:0]      lo_bits; // product bits retired by the rows

    // Row zero starts from an empty sum.
    assign acc[0] = '0;

    for (genvar r = 0; r < W; r++) begin : g_row
        logic [W-1:0] pp;
        logic [W-1:0] sum;
        logic [W:0]   cy;

        // Partial product of this row: a gated by one bit of b.
        assign pp    = a_i & {W{b_i[r]}};
        assign cy[0] = 1'b0;

        for (genvar c = 0; c < W; c++) begin : g_cell
            // One full-adder cell of the row.
            assign sum[c]  = fa_sum(acc[r][c], pp[c], cy[c]);
            assign cy[c+1] = fa_carry(acc[r][c], pp[c], cy[c]);
        end

        // Retire the low bit, shift the rest down into the next row.
        assign lo_bits[r]  = sum[0];
        assign acc[r+1]    = {cy[W], sum[W-1:1]};
    end

    // Final product: last row's sum above the retired bits.
    assign p_o = {acc[W], lo_bits};

endmodule

// File: rtl/pmul_rca.sv
// Module pmul_rca
// W-bit ripple-carry adder built from a chain of full adders.
// Purely combinational.
module pmul_rca #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    import pmul_pkg::*;

    logic [W:0] cy;

    assign cy[0] = c_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One full adder of the ripple chain.
        assign s_o[i]  = fa_sum(x_i[i], y_i[i], cy[i]);
        assign cy[i+1] = fa_carry(x_i[i], y_i[i], cy[i]);
    end

    assign c_o = cy[W];

endmodule

// File: rtl/pmul_cla.sv
// Module pmul_cla
// W-bit two-level carry-lookahead adder. Bits are grouped in fours, and each
// group forms its own generate/propagate pair. A second lookahead level spans
// all groups. Assumes W is a multiple of CLA_GROUP_W and no more than 64.
module pmul_cla #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    import pmul_pkg::*;

    localparam int unsigned GW = CLA_GROUP_W;
    localparam int unsigned NG = W / GW;

    logic [W-1:0]  gen;
    logic [W-1:0]  prp;
    logic [W-1:0]  bit_c;
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [NG:0]   grp_c;

    // Bit-level generate and propagate.
    assign gen = x_i & y_i;
    assign prp = x_i ^ y_i;

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        // Group propagate and generate over four bits.
        assign grp_p[gi] = &prp[gi*GW +: GW];
        assign grp_g[gi] = la_carry(64'(gen[gi*GW +: GW]), 64'(prp[gi*GW +: GW]), 1'b0, int'(GW));
        // Second-level lookahead: carry into this group.
        assign grp_c[gi] = la_carry(64'(grp_g), 64'(grp_p), c_i, gi);

        for (genvar bi = 0; bi < GW; bi++) begin : g_bit
            // First-level lookahead: carry into each bit of the group.
            assign bit_c[gi*GW+bi] = la_carry(64'(gen[gi*GW +: GW]), 64'(prp[gi*GW +: GW]),
                                              grp_c[gi], bi);
        end
    end

    // Carry out of the most significant group.
    assign grp_c[NG] = la_carry(64'(grp_g), 64'(grp_p), c_i, int'(NG));
    assign c_o       = grp_c[NG];
    assign s_o       = prp ^ bit_c;

endmodule

// File: rtl/pmul_incsel.sv
// Module pmul_incsel
// Carry-select upper field. It builds the field plus one with a half-adder
// chain and returns either the field or its incremented copy, picked by
// sel_i. SPLIT_LSB = 1 builds the lowest bit with a full adder whose second
// input is the constant one, followed by a (W-1)-bit half-adder chain.
// Assumes the incremented value never overflows W bits when sel_i is set.
module pmul_incsel #(
    parameter int unsigned W         = 16,
    parameter bit          SPLIT_LSB = 1'b0
) (
    input  logic [W-1:0] x_i,
    input  logic         sel_i,
    output logic [W-1:0] y_o
);
    import pmul_pkg::*;

    logic [W-1:0] inc;
    logic [W-1:0] hc;

    // The constant one that is added.
    assign hc[0] = 1'b1;

    if (SPLIT_LSB) begin : g_split_lsb
        // Lowest bit from a full adder: x + 1 + 0.
        assign inc[0] = fa_sum(x_i[0], hc[0], 1'b0);
        assign hc[1]  = fa_carry(x_i[0], hc[0], 1'b0);
    end else begin : g_plain_lsb
        // Lowest bit from a half adder.
        assign inc[0] = x_i[0] ^ hc[0];
        assign hc[1]  = x_i[0] & hc[0];
    end

    for (genvar i = 1; i < W; i++) begin : g_ha
        // Half-adder stage of the incrementer.
        assign inc[i] = x_i[i] ^ hc[i];
        if (i < W - 1) begin : g_carry
            assign hc[i+1] = x_i[i] & hc[i];
        end
    end

    // The selecting multiplexer.
    assign y_o = sel_i ? inc : x_i;

endmodule

// File: rtl/pmul_pair_merge.sv
// Module pmul_pair_merge
// Joins two 2H-bit sub-products that share one operand half into a 3H-bit
// result: unsh_i + (sh_i << H). The low H bits of unsh_i pass straight
// through. The middle H bits come from a ripple adder. The top H bits are
// carry-selected. Combinational; assumes the sum fits in 3H bits.
module pmul_pair_merge #(
    parameter int unsigned H = 16
) (
    input  logic [2*H-1:0] unsh_i,
    input  logic [2*H-1:0] sh_i,
    output logic [3*H-1:0] m_o
);
    logic [H-1:0] mid;
    logic [H-1:0] top;
    logic         mid_c;

    // Middle field: upper half of the unshifted product plus lower half of the shifted one.
    pmul_rca #(.W(H)) u_mid (
        .x_i (unsh_i[2*H-1:H]),
        .y_i (sh_i[H-1:0]),
        .c_i (1'b0),
        .s_o (mid),
        .c_o (mid_c)
    );

    // Top field: plain or plus-one copy, picked by the middle carry.
    pmul_incsel #(.W(H), .SPLIT_LSB(1'b0)) u_top (
        .x_i   (sh_i[2*H-1:H]),
        .sel_i (mid_c),
        .y_o   (top)
    );

    assign m_o = {top, mid, unsh_i[H-1:0]};

endmodule

// File: rtl/pmul_top.sv
// Module pmul_top
// Unsigned (2*HALF_W)x(2*HALF_W) multiplier built from four parallel
// HALF_W-square array multipliers. Two pair merges and one final merge join
// the sub-products. Every upper-field carry is resolved by carry-select.
// OUT_REG = 1 adds one output register with a synchronous active-low reset.
// TOP_SPLIT_INC picks how the topmost incrementer is built.
// Assumes HALF_W is a multiple of 4 and no more than 64.
module pmul_top #(
    parameter int unsigned HALF_W        = 16,
    parameter bit          OUT_REG       = 1'b1,
    parameter bit          TOP_SPLIT_INC = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*HALF_W-1:0]   a,
    input  logic [2*HALF_W-1:0]   b,
    output logic [4*HALF_W-1:0]   prod
);
    localparam int unsigned OP_W   = 2 * HALF_W;
    localparam int unsigned PART_W = 3 * HALF_W;
    localparam int unsigned PROD_W = 4 * HALF_W;

    // Sub-product k: bit 0 picks the half of a, bit 1 picks the half of b.
    logic [3:0][OP_W-1:0]   sub_p;
    logic [1:0][PART_W-1:0] part;
    logic [HALF_W-1:0]      seg_lo;
    logic [HALF_W-1:0]      seg_mid;
    logic [HALF_W-1:0]      seg_top;
    logic                   c_lo;
    logic                   c_mid;
    logic [PROD_W-1:0]      prod_c;

    for (genvar k = 0; k < 4; k++) begin : g_sub
        // One HALF_W-square array multiplier per pairing of halves.
        pmul_array #(.W(HALF_W)) u_arr (
            .a_i (a[(k % 2) * HALF_W +: HALF_W]),
            .b_i (b[(k / 2) * HALF_W +: HALF_W]),
            .p_o (sub_p[k])
        );
    end

    for (genvar j = 0; j < 2; j++) begin : g_pair
        // Pair sharing half j of b: a_lo*b_j unshifted, a_hi*b_j shifted.
        pmul_pair_merge #(.H(HALF_W)) u_pair (
            .unsh_i (sub_p[2*j]),
            .sh_i   (sub_p[2*j+1]),
            .m_o    (part[j])
        );
    end

    // Final overlap, lower segment: lookahead adder.
    pmul_cla #(.W(HALF_W)) u_fin_lo (
        .x_i (part[0][2*HALF_W-1:HALF_W]),
        .y_i (part[1][HALF_W-1:0]),
        .c_i (1'b0),
        .s_o (seg_lo),
        .c_o (c_lo)
    );

    // Final overlap, upper segment: ripple adder.
    pmul_rca #(.W(HALF_W)) u_fin_mid (
        .x_i (part[0][PART_W-1:2*HALF_W]),
        .y_i (part[1][2*HALF_W-1:HALF_W]),
        .c_i (c_lo),
        .s_o (seg_mid),
        .c_o (c_mid)
    );

    // Topmost field: carry-selected so no carry ripples into it.
    pmul_incsel #(.W(HALF_W), .SPLIT_LSB(TOP_SPLIT_INC)) u_fin_top (
        .x_i   (part[1][PART_W-1:2*HALF_W]),
        .sel_i (c_mid),
        .y_o   (seg_top)
    );

    assign prod_c = {seg_top, seg_mid, seg_lo, part[0][HALF_W-1:0]};

    if (OUT_REG) begin : g_oreg
        // Output register: clear on reset, else capture the product.
        always_ff @(posedge clk) begin
            if (!rst_n) prod <= '0;
            else        prod <= prod_c;
        end
    end else begin : g_comb
        assign prod = prod_c;
    end

endmodule

// File: rtl/pmul_chk.sv
// Module pmul_chk
// Property checker for pmul_top, attached by the bind at the end of this file.
// With the output register it checks the port behaviour one cycle late.
// Without it, the checks are made at each rising edge while reset is released.
module pmul_chk #(
    parameter int unsigned HALF_W  = 16,
    parameter bit          OUT_REG = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*HALF_W-1:0] a,
    input logic [2*HALF_W-1:0] b,
    input logic [4*HALF_W-1:0] prod
);
    localparam int unsigned PW = 4 * HALF_W;
    localparam int unsigned LW = 2 * HALF_W;

    logic          seen = 1'b0;
    logic [PW-1:0] full_ref;
    logic [LW-1:0] lo_ref;

    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) seen <= 1'b1;

    // Behavioural reference products.
    assign full_ref = PW'(a) * PW'(b);
    assign lo_ref   = LW'(a[HALF_W-1:0]) * LW'(b[HALF_W-1:0]);

    if (OUT_REG) begin : g_seq
        // R3
        rst_clear_chk: assert property (@(posedge clk) disable iff (!seen)
            !$past(rst_n) |-> prod == '0);

        // R1
        full_prod_chk: assert property (@(posedge clk) disable iff (!seen || !rst_n)
            $past(rst_n) |-> prod == $past(full_ref));

        // R4
        low_pass_chk: assert property (@(posedge clk) disable iff (!seen || !rst_n)
            $past(rst_n) |-> prod[HALF_W-1:0] == $past(lo_ref[HALF_W-1:0]));

        // R7
        zero_op_chk: assert property (@(posedge clk) disable iff (!seen || !rst_n)
            ($past(rst_n) && ($past(a) == '0 || $past(b) == '0)) |-> prod == '0);

        // R7
        unit_op_chk: assert property (@(posedge clk) disable iff (!seen || !rst_n)
            ($past(rst_n) && $past(b) == LW'(1)) |-> prod == PW'($past(a)));
    end else begin : g_comb
        // Immediate checks of the combinational product at each edge.
        always @(posedge clk) begin
            if (rst_n) begin
                // R1
                comb_full_chk: assert (prod == full_ref);
                // R4
                comb_low_chk: assert (prod[HALF_W-1:0] == lo_ref[HALF_W-1:0]);
                // R7
                comb_zero_chk: assert (!(a == '0 || b == '0) || prod == '0);
                // R7
                comb_unit_chk: assert (b != LW'(1) || prod == PW'(a));
            end
        end
    end

endmodule

bind pmul_top pmul_chk #(.HALF_W(HALF_W), .OUT_REG(OUT_REG)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .prod  (prod)
);

// File: tb/pmul_top_tb_top.sv
// Bench for pmul_top: a plain instance and a split-incrementer instance are
// fed the same operands. Each registered product is checked against a
// behavioural multiply one cycle after the operands are driven.
module pmul_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_r = '0;
    logic [31:0] b_r = '0;
    logic [63:0] prod_plain;
    logic [63:0] prod_split;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Pending expectation for the operands driven last cycle.
    bit          pend_valid = 1'b0;
    logic [63:0] pend_exp = '0;
    string       pend_tag = "";

    // Carry-select coverage counters.
    int px0 = 0, px1 = 0, py0 = 0, py1 = 0, ft0 = 0, ft1 = 0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    pmul_top #(.HALF_W(16), .OUT_REG(1'b1), .TOP_SPLIT_INC(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .a(a_r), .b(b_r), .prod(prod_plain)
    );

    pmul_top #(.HALF_W(16), .OUT_REG(1'b1), .TOP_SPLIT_INC(1'b1)) dut_split_i (
        .clk(clk), .rst_n(rst_n), .a(a_r), .b(b_r), .prod(prod_split)
    );

    task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_int(input string tag, input bit ok, input int got);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=nonzero", tag, got);
        end
    endtask

    // Compare both instances against the pending expectation.
    task automatic compare_pending();
        if (pend_valid) begin
            check64({pend_tag, " plain"}, prod_plain, pend_exp);
            check64({pend_tag, " R9 split"}, prod_split, pend_exp);
        end
    endtask

    // Tally which way each carry-select multiplexer goes for these operands.
    task automatic tally(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] xl, xh, yl, yh, xs, ys, s1, s2;
        xl = 64'(a[15:0]) * 64'(b[15:0]);
        xh = 64'(a[31:16]) * 64'(b[15:0]);
        yl = 64'(a[15:0]) * 64'(b[31:16]);
        yh = 64'(a[31:16]) * 64'(b[31:16]);
        if (((xl >> 16) + (xh & 64'hFFFF)) >= 64'h10000) px1++; else px0++;
        if (((yl >> 16) + (yh & 64'hFFFF)) >= 64'h10000) py1++; else py0++;
        xs = 64'(a) * 64'(b[15:0]);
        ys = 64'(a) * 64'(b[31:16]);
        s1 = ((xs >> 16) & 64'hFFFF) + (ys & 64'hFFFF);
        s2 = ((xs >> 32) & 64'hFFFF) + ((ys >> 16) & 64'hFFFF) + (s1 >> 16);
        if (s2 >= 64'h10000) ft1++; else ft0++;
    endtask

    // Drive one operand pair; check the previous pair at the same time.
    task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        compare_pending();
        a_r = a;
        b_r = b;
        pend_exp = 64'(a) * 64'(b);
        pend_tag = tag;
        pend_valid = 1'b1;
        tally(a, b);
    endtask

    task automatic flush();
        @(negedge clk);
        compare_pending();
        pend_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R3: reset with non-zero operands keeps the product at zero.
        a_r = 32'hDEAD_BEEF;
        b_r = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check64("R3 reset plain", prod_plain, 64'h0);
        check64("R3 reset split", prod_split, 64'h0);
        rst_n = 1'b1;

        // R8: all-ones operands.
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 all-ones");
        flush();
        check64("R8 all-ones constant", prod_plain, 64'hFFFF_FFFE_0000_0001);

        // R7: zero and unit operands.
        send(32'h0, 32'hFFFF_FFFF, "R7 zero a");
        send(32'hFFFF_FFFF, 32'h0, "R7 zero b");
        send(32'h8765_4321, 32'h1, "R7 unit b");
        flush();
        check64("R7 unit b passes a", prod_plain, 64'h0000_0000_8765_4321);

        // R8: walking single-bit operands at several offsets.
        for (int i = 0; i < 32; i++) begin
            send(32'h1 << i, 32'h1 << (31 - i), "R8 single-bit");
            send(32'h1 << i, 32'h1 << ((i * 7) % 32), "R8 single-bit");
        end
        flush();

        // R4: low halves only, so the low field carries the whole product.
        send(32'h0000_FFFF, 32'h0000_FFFF, "R4 low halves");
        send(32'hFFFF_ABCD, 32'hFFFF_1234, "R4 low field");
        flush();
        check64("R4 low 16 bits", {48'h0, prod_plain[15:0]},
                {48'h0, 16'((32'hABCD * 32'h1234) & 32'hFFFF)});

        // R5 and R6: carry-heavy patterns, then random back-to-back vectors (R1, R2).
        send(32'hFFFF_FFFF, 32'h0000_FFFF, "R5 pair carry");
        send(32'hFFFF_8000, 32'hFFFF_FFFF, "R6 top carry");
        send(32'h8000_FFFF, 32'hFFFF_8001, "R6 top carry");
        for (int n = 0; n < 600; n++) begin
            send($urandom(), $urandom(), "R1 R2 random");
        end
        for (int n = 0; n < 200; n++) begin
            send($urandom() | 32'hFFF0_0000, $urandom() | 32'hFFF0_0000, "R5 R6 dense");
        end
        flush();

        // R3: reset taken mid-stream clears a non-zero product.
        send(32'h1357_9BDF, 32'h2468_ACE0, "R2 before reset");
        flush();
        @(negedge clk);
        rst_n = 1'b0;
        a_r = 32'hFFFF_FFFF;
        b_r = 32'hFFFF_FFFF;
        @(negedge clk);
        check64("R3 mid-run reset plain", prod_plain, 64'h0);
        check64("R3 mid-run reset split", prod_split, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R2 after reset release", prod_plain, 64'hFFFF_FFFE_0000_0001);

        // R5 and R6: every multiplexer was driven both ways.
        check_int("R5 low pair carry=0 seen", px0 > 0, px0);
        check_int("R5 low pair carry=1 seen", px1 > 0, px1);
        check_int("R5 high pair carry=0 seen", py0 > 0, py0);
        check_int("R5 high pair carry=1 seen", py1 > 0, py1);
        check_int("R6 top carry=0 seen", ft0 > 0, ft0);
        check_int("R6 top carry=1 seen", ft1 > 0, ft1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule